// File: doc/BRIEF.md
# Cross-Domain Event Pulse Bridge

This block carries single-cycle event pulses from one clock and power domain to another over a fixed set of channels. Source channel i is always wired to destination channel i. Pulses travel in one direction only, and the mapping cannot be changed at run time. Each channel turns an incoming pulse into a level change on the source side and passes that level through a multi-flop synchroniser on the destination clock. An edge detector on the destination side turns the level change back into an event.

The destination domain may be powered down. A recovered event therefore waits in a per-channel pending flag until the destination reports that it is ready. While a pulse waits, the bridge raises a wake request. Once ready is high, the event leaves as a pulse one destination cycle wide. A constant-latency input holds the wake request high at all times, so delivery never waits for a power-up. A second event that reaches a channel while that channel is still holding an undelivered one is merged into the held event. The merge is recorded in a sticky per-channel overflow flag.

Events on a single channel must be at least three destination clock periods apart. A closer pair cancels out in the level-change encoding and is not guaranteed to arrive.

Top module: `xdom_event_bridge`

## Requirements
- R1: An event on source channel i appears only on destination output bit i. No other destination bit pulses.
- R2: Every one-cycle source event that respects the channel spacing rule is delivered exactly once, on any pattern of channels, including several channels at the same time.
- R3: Each delivered event is high on `dst_evt` for exactly one destination clock cycle.
- R4: While `dst_ready` is low, `dst_evt` stays zero and held events are kept. After `dst_ready` goes high, each held event is emitted once.
- R5: `wake_req` is a registered output. It goes high one destination cycle after some channel is holding an event while `dst_ready` is low. It returns low once nothing is held and `const_lat` is low.
- R6: While `const_lat` is high, `wake_req` is high from the next destination cycle on, even with no event held.
- R7: A second event on channel i that is recovered while the first is still held (because `dst_ready` is low) produces a single delivered pulse. It sets `ovf[i]`, which stays set until destination reset. Other channels' overflow bits stay clear.
- R8: After reset, `dst_evt`, `wake_req` and `ovf` are all zero.
- R9: With `dst_ready` high, an event is delivered within 8 destination clock cycles of the source cycle that carried it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_evt | input | NUM_CH | One-cycle event pulses, one bit per channel, on `src_clk` |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_ready | input | 1 | Destination domain is awake and can accept events |
| const_lat | input | 1 | Constant-latency mode: keep the wake request asserted |
| dst_evt | output | NUM_CH | One-cycle delivered event pulses on `dst_clk` |
| wake_req | output | 1 | Registered request to wake the destination domain |
| ovf | output | NUM_CH | Sticky per-channel flag: events were merged |

## Verification
The hardest situation to reach from the ports is an overflow merge. A second event must cross the synchroniser while the first is still held. Both events must still obey the spacing rule, or the toggle encoding cancels them before either is seen. The stimulus drops `dst_ready`, sends one event, waits several destination cycles so that the first event is held, and then sends a second event on the same channel. Only after that does it raise `dst_ready`. It then checks that exactly one pulse came out and that only that channel's overflow bit is set.

// File: rtl/xdb_pkg.sv
package xdb_pkg;

  // Next value of a channel's hold flag: a fresh edge always arms it,
  // otherwise it persists only while the destination is not ready.
  function automatic logic f_hold_next(logic edge_seen, logic held, logic ready);
    return edge_seen | (held & ~ready);
  endfunction

  // A merge happens when a new edge arrives on a channel whose previous
  // event is still held and cannot leave this cycle.
  function automatic logic f_merge(logic edge_seen, logic held, logic ready);
    return edge_seen & held & ~ready;
  endfunction

  // Wake request: forced by constant-latency mode, or needed while events wait.
  function automatic logic f_wake(logic cl_mode, logic any_held, logic ready);
    return cl_mode | (any_held & ~ready);
  endfunction

endpackage

// File: rtl/xdb_src_toggle.sv
module xdb_src_toggle #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  output logic [NUM_CH-1:0] lvl
);

  logic [NUM_CH-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_q ^ evt;
  end

  assign lvl = lvl_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_chk
      // R2: every accepted source event flips that channel's level
      a_r2_event_flips_level: assert property (@(posedge clk) disable iff (!rst_n)
        evt[gi] |=> (lvl[gi] != $past(lvl[gi])));
      // R1: a channel's level never moves without its own event
      a_r1_level_own_channel: assert property (@(posedge clk) disable iff (!rst_n)
        !evt[gi] |=> $stable(lvl[gi]));
    end
  endgenerate

endmodule

// File: rtl/xdb_sync.sv
module xdb_sync #(
  parameter int NUM_CH = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] d,
  output logic [NUM_CH-1:0] q
);

  localparam int LAST = STAGES - 1;

  logic [NUM_CH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[LAST];

endmodule

// File: rtl/xdb_dst_hold.sv
module xdb_dst_hold
  import xdb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] lvl_sync,
  input  logic              ready,
  input  logic              cl_mode,
  output logic [NUM_CH-1:0] evt_out,
  output logic              wake,
  output logic [NUM_CH-1:0] merged
);

  logic [NUM_CH-1:0] lvl_prev;
  logic [NUM_CH-1:0] edge_seen;
  logic [NUM_CH-1:0] held;
  logic [NUM_CH-1:0] held_next;
  logic [NUM_CH-1:0] merge_now;
  logic [NUM_CH-1:0] emit_now;
  logic [NUM_CH-1:0] evt_q;
  logic [NUM_CH-1:0] merged_q;
  logic              wake_q;
  logic              any_held;

  assign edge_seen = lvl_sync ^ lvl_prev;
  assign any_held  = |held;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      assign held_next[gi] = f_hold_next(edge_seen[gi], held[gi], ready);
      assign merge_now[gi] = f_merge(edge_seen[gi], held[gi], ready);
      assign emit_now[gi]  = held[gi] & ready;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= '0;
      held     <= '0;
      evt_q    <= '0;
      merged_q <= '0;
      wake_q   <= 1'b0;
    end else begin
      lvl_prev <= lvl_sync;
      held     <= held_next;
      evt_q    <= emit_now;
      merged_q <= merged_q | merge_now;
      wake_q   <= f_wake(cl_mode, any_held, ready);
    end
  end

  assign evt_out = evt_q;
  assign wake    = wake_q;
  assign merged  = merged_q;

  // R4: nothing leaves while the destination is not ready
  a_r4_hold_while_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (evt_out == '0));
  // R6: constant-latency mode keeps the wake request up
  a_r6_const_wake: assert property (@(posedge clk) disable iff (!rst_n)
    cl_mode |=> wake);
  // R5: a waiting event with the destination asleep requests a wake
  a_r5_wake_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (any_held && !ready) |=> wake);

  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_chk
      // R7: overflow flags are sticky
      a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        merged[gi] |=> merged[gi]);
      // R3: delivered pulses last one cycle
      a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out[gi] |=> !evt_out[gi]);
      // R4: a held event survives until the destination is ready
      a_r4_held_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (held[gi] && !ready) |=> held[gi]);
    end
  endgenerate

endmodule

// File: rtl/xdom_event_bridge.sv
module xdom_event_bridge #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic [NUM_CH-1:0] src_evt,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  input  logic              dst_ready,
  input  logic              const_lat,
  output logic [NUM_CH-1:0] dst_evt,
  output logic              wake_req,
  output logic [NUM_CH-1:0] ovf
);

  localparam int STAGES_USED = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NUM_CH-1:0] src_lvl;
  logic [NUM_CH-1:0] dst_lvl;

  xdb_src_toggle #(.NUM_CH(NUM_CH)) u_src (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .evt   (src_evt),
    .lvl   (src_lvl)
  );

  xdb_sync #(.NUM_CH(NUM_CH), .STAGES(STAGES_USED)) u_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (src_lvl),
    .q     (dst_lvl)
  );

  xdb_dst_hold #(.NUM_CH(NUM_CH)) u_dst (
    .clk      (dst_clk),
    .rst_n    (dst_rst_n),
    .lvl_sync (dst_lvl),
    .ready    (dst_ready),
    .cl_mode  (const_lat),
    .evt_out  (dst_evt),
    .wake     (wake_req),
    .merged   (ovf)
  );

  // R5: with no wake reason for a cycle, the wake request drops
  a_r5_wake_drops: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (!const_lat && dst_ready) |=> !wake_req);

endmodule

// File: tb/xdom_event_bridge_tb.sv
module xdom_event_bridge_tb;

  localparam int N = 4;

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         src_rst_n = 1'b0;
  logic         dst_rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic         dst_ready = 1'b0;
  logic         const_lat = 1'b0;
  logic [N-1:0] dst_evt;
  logic         wake_req;
  logic [N-1:0] ovf;

  int checks = 0;
  int errors = 0;
  int cnt [N];
  int exp_cnt [N];
  int width_err = 0;
  logic [N-1:0] prev_evt = '0;
  bit done = 0;

  always #4   src_clk = ~src_clk;   // 125 MHz
  always #5.5 dst_clk = ~dst_clk;

  xdom_event_bridge #(.NUM_CH(N), .SYNC_STAGES(2)) u_dut (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_evt   (src_evt),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_ready (dst_ready),
    .const_lat (const_lat),
    .dst_evt   (dst_evt),
    .wake_req  (wake_req),
    .ovf       (ovf)
  );

  initial for (int i = 0; i < N; i++) begin cnt[i] = 0; exp_cnt[i] = 0; end

  // Count delivered pulses and measure their width away from the active edge.
  always @(negedge dst_clk) begin
    for (int i = 0; i < N; i++) begin
      if (dst_evt[i]) cnt[i] = cnt[i] + 1;
      if (dst_evt[i] && prev_evt[i]) width_err = width_err + 1;
    end
    prev_evt = dst_evt;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [N-1:0] mask);
    @(negedge src_clk);
    src_evt = mask;
    @(negedge src_clk);
    src_evt = '0;
  endtask

  task automatic dwait(input int n);
    for (int k = 0; k < n; k++) @(negedge dst_clk);
  endtask

  function automatic bit counts_match();
    for (int i = 0; i < N; i++) if (cnt[i] != exp_cnt[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int mism_sum();
    int s = 0;
    for (int i = 0; i < N; i++) s += (cnt[i] > exp_cnt[i]) ? cnt[i] - exp_cnt[i] : exp_cnt[i] - cnt[i];
    return s;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (4) @(negedge src_clk);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    dwait(2);

    // R8: reset state
    check(dst_evt == '0, "R8 dst_evt", int'(dst_evt), 0);
    check(wake_req == 1'b0, "R8 wake_req", int'(wake_req), 0);
    check(ovf == '0, "R8 ovf", int'(ovf), 0);

    // R1, R9: each channel alone, ready high, latency bound
    dst_ready = 1'b1;
    dwait(2);
    for (int ch = 0; ch < N; ch++) begin
      int lat = 99;
      int base = cnt[ch];
      send(N'(1) << ch);
      exp_cnt[ch]++;
      for (int k = 1; k <= 12; k++) begin
        @(negedge dst_clk);
        if (cnt[ch] != base && lat == 99) lat = k;
      end
      check(lat <= 8, "R9 latency", lat, 8);
      check(counts_match(), "R1 mapping", mism_sum(), 0);
    end

    // R4, R5: held while asleep, wake requested, released on ready
    dst_ready = 1'b0;
    dwait(2);
    send(4'b0100);
    exp_cnt[2]++;
    dwait(10);
    check(cnt[2] == exp_cnt[2] - 1, "R4 no delivery while asleep", cnt[2], exp_cnt[2] - 1);
    check(wake_req == 1'b1, "R5 wake while held", int'(wake_req), 1);
    dst_ready = 1'b1;
    dwait(10);
    check(counts_match(), "R4 released once", mism_sum(), 0);
    check(wake_req == 1'b0, "R5 wake drops", int'(wake_req), 0);

    // R7: merge while held
    dst_ready = 1'b0;
    dwait(2);
    send(4'b0010);
    dwait(10);
    send(4'b0010);
    exp_cnt[1]++;
    dwait(10);
    check(ovf == 4'b0010, "R7 ovf set", int'(ovf), 2);
    check(wake_req == 1'b1, "R5 wake during merge", int'(wake_req), 1);
    dst_ready = 1'b1;
    dwait(10);
    check(counts_match(), "R7 single merged delivery", mism_sum(), 0);
    check(ovf == 4'b0010, "R7 ovf sticky", int'(ovf), 2);

    // R6: constant-latency mode
    const_lat = 1'b1;
    dwait(3);
    check(wake_req == 1'b1, "R6 const wake", int'(wake_req), 1);
    dst_ready = 1'b0;
    dwait(3);
    check(wake_req == 1'b1, "R6 const wake asleep", int'(wake_req), 1);
    dst_ready = 1'b1;
    const_lat = 1'b0;
    dwait(3);
    check(wake_req == 1'b0, "R6 const released", int'(wake_req), 0);

    // R2: random channel patterns, spacing kept
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] m = N'($urandom % (1 << N));
      send(m);
      for (int i = 0; i < N; i++) if (m[i]) exp_cnt[i]++;
      repeat (6 + ($urandom % 4)) @(negedge src_clk);
    end
    dwait(20);
    check(counts_match(), "R2 random delivery count", mism_sum(), 0);
    // R3: pulse width
    check(width_err == 0, "R3 single-cycle pulses", width_err, 0);
    check(ovf == 4'b0010, "R7 other channels clear", int'(ovf), 2);

    summary();
  end

endmodule